// File: doc/BRIEF.md
# Dual-Role SPI Engine with Mode-Fault Detection

This block is a byte-oriented SPI peripheral that can drive a four-wire, full-duplex bus as the clocking master, or answer on it as a selected slave. One shift register handles both roles. Each bit it pushes out is paired with one bit it captures from the opposite data line. In master mode the block makes the serial clock itself from a programmable divisor. In slave mode it passes the incoming clock, select and data pins through synchronisers and acts on edges of the synchronised clock.

Software uses four byte-wide locations. It writes control settings, a clock divisor and transmit data. It reads back received data and a status byte, and it clears flags by writing ones to them. A single interrupt line is high while any completion or error flag is set. If another device pulls the select line low while this block is master, the block reports a mode fault, gives up mastership and releases its clock and data-out drivers.

Top module: `duplex_spi_engine`

## Requirements
- R1: Register map, selected by `addr`. At 0 is control: bit0 enable, bit1 master, bit2 clock polarity, bit3 clock phase, bits 6:4 bit count. At 1 is the divisor. At 2, a write gives transmit data and a read gives received data. At 3 is status: bit0 done, bit1 write collision, bit2 overrun, bit3 mode fault, bit4 busy, bit5 selected as slave. Writing a 1 to status bits 0 to 3 clears them. After reset every location reads 0, `irq` is 0 and no output enable is active.
- R2: A master transfer starts when transmit data is written while enabled, master and idle. Data goes out on MOSI most significant bit first, and one MISO bit is captured for each bit sent.
- R3: The master SCK half-period is divisor+1 system clocks, so SCK is never faster than half the system clock. The first SCK edge comes divisor+1 cycles after the cycle that accepts the write.
- R4: While the block is enabled as master, a low synchronised NSS sets the mode-fault flag, clears the master bit, aborts any transfer and drops the SCK and MOSI output enables.
- R5: Bit count N is 1 to 7, and the value 0 means 8. Bits N-1..0 of the transmit byte are sent, highest first. The received bits land in bits N-1..0 of the receive byte and the upper bits read 0.
- R6: At the end of every frame the done flag is set and `irq` rises. It stays high until the flag is cleared.
- R7: A transmit-data write while a transfer is in progress sets the write-collision flag and is discarded. The running frame is unaffected.
- R8: If a frame completes while done is still set and the previous received byte is unread, the overrun flag is set and the old byte is kept.
- R9: In slave mode with NSS high, SCK edges are ignored, no frame completes, and MISO is undriven (`miso_oe` low, `miso_o` low).
- R10: A selected slave transfers full-duplex correctly with SCK at one tenth of the system clock. It presents its transmit byte on MISO, highest bit first, and captures MOSI.
- R11: A selected slave that only receives captures MOSI correctly when SCK edges arrive on consecutive system clocks, with the inputs synchronous to the system clock.
- R12: If NSS rises in the middle of a slave frame, the partial frame is dropped without setting done, and the next frame starts from its first bit.
- R13: SCK stays at the clock-polarity level whenever a master is not transferring. With phase 0, data is sampled on the first edge of each bit; with phase 1, on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (marks received data as read at address 2) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | High while done, collision, overrun or mode fault is set |
| sck_i | input | 1 | Serial clock from the bus (slave) |
| sck_o | output | 1 | Serial clock driven (master) |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | Data in from the bus (slave) |
| mosi_o | output | 1 | Data out (master) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Data in from the bus (master) |
| miso_o | output | 1 | Data out (slave) |
| miso_oe | output | 1 | MISO output enable |
| nss_i | input | 1 | Active-low slave select |

## Verification
The bench builds the block with a 4-bit divisor and two synchroniser stages. The narrow divisor makes its top value of 15 cheap to run next to the fastest setting of 0, so both ends of the SCK rate range are covered in a short run. The two-stage synchroniser gives a fixed three-cycle slave reaction time. That is short enough for a one-tenth-rate full-duplex exchange to check every MISO bit, and it leaves the one-edge-per-cycle receive-only case to show that the data and clock pipelines stay aligned.

// File: rtl/duplex_spi_engine.sv
module duplex_spi_engine #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       nss_i
);
  localparam int SP = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic             en, ms, cpol, cpha;
  logic [2:0]       bc;
  logic [DIV_W-1:0] div, cnt;
  logic [7:0]       sh, rx;
  logic             rbit, run, tgl;
  logic [3:0]       ecnt;
  logic             done, wcol, ovr, modf, unread;
  logic [SP:0]      sck_p;
  logic [SP-1:0]    mosi_p, nss_p;

  wire sck_s  = sck_p[SP-1];
  wire sck_d  = sck_p[SP];
  wire mosi_s = mosi_p[SP-1];
  wire nss_s  = nss_p[SP-1];

  wire [3:0] nbits  = (bc == 3'd0) ? 4'd8 : {1'b0, bc};
  wire [4:0] last_e = {nbits, 1'b0} - 5'd1;

  wire slv_sel = en & ~ms & ~nss_s;
  wire busy    = run | (ecnt != 4'd0);
  wire mev     = run & (cnt == div);
  wire sev     = slv_sel & (sck_s ^ sck_d);
  wire ev      = ms ? mev : sev;
  wire din     = ms ? miso_i : mosi_s;
  wire smp     = ~ecnt[0] ^ cpha;
  wire fin     = ev & (ecnt == last_e[3:0]);
  wire [7:0] fin_val = cpha ? {sh[6:0], din} : {sh[6:0], rbit};

  wire fault  = en & ms & ~nss_s;
  wire abort  = ~en | fault | (~ms & nss_s);
  wire wr_ctl = wr_en & (addr == 2'd0);
  wire wr_div = wr_en & (addr == 2'd1);
  wire wr_dat = wr_en & (addr == 2'd2);
  wire wr_sts = wr_en & (addr == 2'd3);
  wire start  = wr_dat & en & ~busy;
  wire [7:0] tx_al = wdata << (4'd8 - nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      mosi_p <= '0;
      nss_p  <= '1;
    end else begin
      sck_p  <= {sck_p[SP-1:0], sck_i};
      mosi_p <= {mosi_p[SP-2:0], mosi_i};
      nss_p  <= {nss_p[SP-2:0], nss_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, ms, cpol, cpha} <= '0;
      bc     <= '0;
      div    <= '0;
      cnt    <= '0;
      sh     <= '0;
      rx     <= '0;
      rbit   <= 1'b0;
      run    <= 1'b0;
      tgl    <= 1'b0;
      ecnt   <= '0;
      done   <= 1'b0;
      wcol   <= 1'b0;
      ovr    <= 1'b0;
      modf   <= 1'b0;
      unread <= 1'b0;
    end else begin
      if (wr_ctl) {bc, cpha, cpol, ms, en} <= wdata[6:0];
      if (wr_div) div <= DIV_W'(wdata);
      if (fault) begin
        ms   <= 1'b0;
        modf <= 1'b1;
      end
      if (wr_sts) begin
        done <= done & ~wdata[0];
        wcol <= wcol & ~wdata[1];
        ovr  <= ovr  & ~wdata[2];
        modf <= (modf & ~wdata[3]) | fault;
      end
      if (wr_dat & busy) wcol <= 1'b1;
      if (rd_en && addr == 2'd2) unread <= 1'b0;

      if (start) begin
        sh <= tx_al;
        if (ms & ~fault) begin
          run <= 1'b1;
          cnt <= '0;
        end
      end

      if (abort) begin
        run  <= 1'b0;
        ecnt <= '0;
        tgl  <= 1'b0;
        cnt  <= '0;
      end else begin
        if (run) cnt <= mev ? '0 : cnt + DIV_W'(1);
        if (ev) begin
          if (ms) tgl <= ~tgl;
          if (smp) rbit <= din;
          else if (!(cpha && ecnt == 4'd0)) sh <= {sh[6:0], rbit};
          if (fin) begin
            sh   <= fin_val;
            ecnt <= '0;
            run  <= 1'b0;
            done <= 1'b1;
            if (done & unread) ovr <= 1'b1;
            else begin
              rx     <= fin_val;
              unread <= 1'b1;
            end
          end else begin
            ecnt <= ecnt + 4'd1;
          end
        end
      end
    end
  end

  assign sck_o   = cpol ^ tgl;
  assign sck_oe  = en & ms;
  assign mosi_o  = ms & sh[7];
  assign mosi_oe = en & ms;
  assign miso_o  = slv_sel & sh[7];
  assign miso_oe = slv_sel;
  assign irq     = done | wcol | ovr | modf;

  always_comb begin
    case (addr)
      2'd0:    rdata = {1'b0, bc, cpha, cpol, ms, en};
      2'd1:    rdata = 8'(div);
      2'd2:    rdata = rx;
      default: rdata = {2'b00, slv_sel, busy, modf, ovr, wcol, done};
    endcase
  end
endmodule

// File: rtl/duplex_spi_engine_props.sv
module duplex_spi_engine_props #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             ms,
  input logic             cpol,
  input logic             busy,
  input logic             nss_s,
  input logic             sck_o,
  input logic             sck_oe,
  input logic [DIV_W-1:0] div,
  input logic             modf,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic             wcol,
  input logic             ovr,
  input logic [7:0]       rx
);
  a_r13_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ms && !busy) |-> (sck_o == cpol));

  a_r4_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ms && !nss_s) |=> (modf && !sck_oe));

  a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && $past(sck_oe) && (sck_o != $past(sck_o)) && (div != '0))
      |=> ($stable(sck_o) || !sck_oe));

  a_r7_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && busy) |=> wcol);

  a_r8_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $stable(rx));
endmodule

bind duplex_spi_engine duplex_spi_engine_props #(.DIV_W(DIV_W)) u_props (
  .clk(clk), .rst_n(rst_n), .en(en), .ms(ms), .cpol(cpol), .busy(busy),
  .nss_s(nss_s), .sck_o(sck_o), .sck_oe(sck_oe), .div(div), .modf(modf),
  .wr_en(wr_en), .addr(addr), .wcol(wcol), .ovr(ovr), .rx(rx)
);

// File: tb/test_duplex_spi_engine.sv
`timescale 1ns/1ps
module test_duplex_spi_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic       sck_i = 0, mosi_i = 0, miso_i = 0, nss_i = 1;
  wire  [7:0] rdata;
  wire        irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int n_cmp = 0, n_bad = 0;

  duplex_spi_engine #(.DIV_W(4), .SYNC_STAGES(2)) i_duplex_spi_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .nss_i(nss_i));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; rd_en = (a == 2'd2);
    #1 v = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic master_xfer(input string req, input logic [7:0] tx, input logic [7:0] pat,
                             input int n, input int d, input bit pl, input bit ph, input bit readback);
    int two_n, total;
    logic [7:0] mcap, mask, v;
    logic [2:0] bcf;
    two_n = 2 * n;
    total = two_n * (d + 1);
    mcap  = 0;
    mask  = (n == 8) ? 8'hFF : ((8'd1 << n) - 8'd1);
    bcf   = n[2:0];
    if (readback) reg_wr(2'd3, 8'h0F);
    reg_wr(2'd0, {1'b0, bcf, ph, pl, 1'b1, 1'b1});
    reg_wr(2'd1, d[7:0]);
    reg_wr(2'd2, tx);
    for (int j = 0; j <= total + 1; j++) begin
      int t, s, e;
      t = j / (d + 1);
      if (t > two_n) t = two_n;
      s = ph ? t / 2 : (t + 1) / 2;
      addr = 2'd3;
      #1;
      check({req, " R3/R13 sck"}, sck_o, pl ^ t[0]);
      check({req, " R2 busy"}, rdata[4], j < total);
      miso_i = (s < n) ? pat[n-1-s] : 1'b0;
      if ((j + 1) % (d + 1) == 0) begin
        e = (j + 1) / (d + 1);
        if (e <= two_n && ((e % 2 == 1) != ph)) mcap[n-1-s] = mosi_o;
      end
      @(negedge clk);
    end
    addr = 2'd3; #1;
    check({req, " R6 done"}, rdata[0], 1'b1);
    check({req, " R6 irq"}, irq, 1'b1);
    check({req, " R2 mosi bits"}, mcap, tx & mask);
    @(negedge clk);
    if (readback) begin
      reg_rd(2'd2, v);
      check({req, " R5 rx"}, v, pat & mask);
    end
  endtask

  task automatic slave_xfer(input string req, input logic [7:0] stx, input logic [7:0] mpat,
                            input int halfp, input bit chk_miso);
    logic [7:0] scap, v;
    scap = 0;
    reg_wr(2'd0, 8'h01);
    reg_wr(2'd3, 8'h0F);
    reg_wr(2'd2, stx);
    nss_i = 0;
    repeat (6) @(negedge clk);
    check({req, " R9 selected miso_oe"}, miso_oe, 1'b1);
    for (int i = 0; i < 8; i++) begin
      mosi_i = mpat[7-i];
      repeat (halfp) @(negedge clk);
      scap[7-i] = miso_o;
      sck_i = 1;
      repeat (halfp) @(negedge clk);
      sck_i = 0;
    end
    repeat (8) @(negedge clk);
    reg_rd(2'd3, v);
    check({req, " R6 slave done"}, v[0], 1'b1);
    nss_i = 1;
    reg_rd(2'd2, v);
    check({req, " rx"}, v, mpat);
    if (chk_miso) check({req, " R10 miso bits"}, scap, stx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all): actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    reg_rd(2'd3, v); check("R1 reset status", v, 8'h00);
    reg_rd(2'd0, v); check("R1 reset ctrl", v, 8'h00);
    check("R1 reset irq", irq, 1'b0);
    check("R1 reset sck_oe", sck_oe, 1'b0);
    check("R1 reset miso_oe", miso_oe, 1'b0);

    master_xfer("R2 mode00", 8'hA5, 8'h3C, 8, 0, 1'b0, 1'b0, 1'b1);
    master_xfer("R3 mode11 div2", 8'h96, 8'h5A, 8, 2, 1'b1, 1'b1, 1'b1);
    master_xfer("R5 five bits", 8'h13, 8'h0B, 5, 1, 1'b0, 1'b0, 1'b1);
    master_xfer("R5 one bit div15", 8'h01, 8'h01, 1, 15, 1'b0, 1'b1, 1'b1);
    master_xfer("R13 mode10", 8'h3E, 8'hC1, 8, 1, 1'b1, 1'b0, 1'b1);

    reg_wr(2'd3, 8'h0F);
    @(negedge clk);
    check("R6 irq cleared", irq, 1'b0);

    reg_wr(2'd1, 8'd3);
    reg_wr(2'd0, 8'h03);
    miso_i = 1;
    reg_wr(2'd2, 8'h5A);
    repeat (4) @(negedge clk);
    reg_wr(2'd2, 8'hFF);
    reg_rd(2'd3, v);
    check("R7 wcol flag", v[1], 1'b1);
    for (int k = 0; k < 200; k++) begin
      addr = 2'd3; #1;
      if (rdata[4] == 1'b0) break;
      @(negedge clk);
    end
    @(negedge clk);
    reg_rd(2'd3, v);
    check("R7 frame still done", v[0], 1'b1);
    reg_rd(2'd2, v);
    check("R7 rx of running frame", v, 8'hFF);

    reg_wr(2'd3, 8'h0F);
    master_xfer("R8 first", 8'h3C, 8'h11, 8, 1, 1'b0, 1'b0, 1'b0);
    master_xfer("R8 second", 8'hC3, 8'h22, 8, 1, 1'b0, 1'b0, 1'b0);
    reg_rd(2'd3, v);
    check("R8 overrun flag", v[2], 1'b1);
    reg_rd(2'd2, v);
    check("R8 old byte kept", v, 8'h11);

    reg_wr(2'd3, 8'h0F);
    reg_wr(2'd0, 8'h03);
    nss_i = 0;
    repeat (4) @(negedge clk);
    reg_rd(2'd3, v);
    check("R4 modf flag", v[3], 1'b1);
    reg_rd(2'd0, v);
    check("R4 master bit cleared", v[1], 1'b0);
    check("R4 sck released", sck_oe, 1'b0);
    check("R4 mosi released", mosi_oe, 1'b0);
    check("R4 irq", irq, 1'b1);
    nss_i = 1;
    reg_wr(2'd3, 8'h0F);
    @(negedge clk);
    check("R4 irq after clear", irq, 1'b0);

    reg_wr(2'd0, 8'h01);
    reg_wr(2'd3, 8'h0F);
    reg_wr(2'd2, 8'hFF);
    for (int k = 0; k < 16; k++) begin
      mosi_i = k[1];
      sck_i = ~sck_i;
      repeat (2) @(negedge clk);
      check("R9 miso_oe low", miso_oe, 1'b0);
      check("R9 miso_o low", miso_o, 1'b0);
    end
    repeat (4) @(negedge clk);
    reg_rd(2'd3, v);
    check("R9 no done", v[0], 1'b0);
    check("R9 not busy", v[4], 1'b0);

    slave_xfer("R10 full duplex", 8'hC3, 8'h69, 5, 1'b1);
    slave_xfer("R11 receive only", 8'h00, 8'hB2, 1, 1'b0);

    reg_wr(2'd3, 8'h0F);
    nss_i = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      mosi_i = 1;
      repeat (3) @(negedge clk);
      sck_i = 1;
      repeat (3) @(negedge clk);
      sck_i = 0;
    end
    repeat (4) @(negedge clk);
    nss_i = 1;
    repeat (8) @(negedge clk);
    reg_rd(2'd3, v);
    check("R12 abort no done", v[0], 1'b0);
    check("R12 abort not busy", v[4], 1'b0);
    slave_xfer("R12 next frame", 8'h5A, 8'h4D, 5, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule